// File: doc/BRIEF.md
# Dual-Rail Receiver with Completion Detection

This block receives a bus in which every data bit travels on its own pair of wires, and it turns that bus into an ordinary binary word with a completion flag. Each bit decides for itself when it has arrived. The block samples all rail pairs on every clock edge and sorts each pair into one of four classes: empty (spacer), zero, one or illegal. It then reduces the per-bit results through balanced trees. One tree reports that every bit is valid, one reports that every bit is back at spacer, and one reports that some bit is illegal.

A two-state phase machine acts as the root hold element of the completion tree. It behaves like a Muller C-element. The done flag goes high only once every bit carries a codeword. It goes low only once every bit has returned to spacer. Any other mix of bits leaves it where it was. The decoded word is captured on the cycle in which done is raised, and it is held until the next rise. The sender is expected to alternate between spacer phases and data phases.

Top module: `dr_completion_rx`

Pair encoding: for bit i the pair is `rails_i[2i+1:2i]`. `00` is spacer, `01` is logic 0, `10` is logic 1 and `11` is illegal. The decoded bit equals the upper wire `rails_i[2i+1]`.

Phase machine states:
- `PH_EMPTY`: done is low.
- `PH_FULL`: done is high.

Phase machine transitions:
- `ARRIVE`: `PH_EMPTY` to `PH_FULL` when all pairs are valid.
- `DRAIN`: `PH_FULL` to `PH_EMPTY` when all pairs are spacer.
- `HOLD`: in every other case the state is kept.

## Requirements
- R1: While reset is asserted, and on the first cycle after it, done_o is 0, err_o is 0 and data_o is all zeros.
- R2: If done_o is low and a sample has every pair at `01` or `10`, done_o is high on the next cycle.
- R3: If done_o is high and a sample has every pair at `00`, done_o is low on the next cycle.
- R4: A sample that is neither all valid nor all spacer leaves done_o unchanged on the next cycle.
- R5: On the cycle after done_o rises, data_o bit i equals the upper wire `rails_i[2i+1]` of the sample that raised it. A pair of `10` gives 1 and a pair of `01` gives 0.
- R6: data_o changes only on a cycle where done_o rises. A new codeword that arrives while done_o is already high, with no spacer in between, is not captured.
- R7: err_o is high on the cycle after any sample containing a `11` pair, and low on the cycle after any sample containing none.
- R8: A `11` pair counts as neither valid nor spacer. A sample with a `11` pair therefore never raises or lowers done_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rails_i | input | 2*WIDTH | Rail pairs, bit i on [2i+1:2i] |
| data_o | output | WIDTH | Decoded word captured at completion |
| done_o | output | 1 | Completion flag with hysteresis |
| err_o | output | 1 | Illegal pair seen in previous sample |

## Verification
The embedded properties check on every cycle that done rises on an all-valid sample and falls on an all-spacer sample. They also check that done holds on any mixed sample, that capture copies the sampled upper wires, and that the word stays stable away from capture. They also tie err to the illegal-pair tree. Only the bench scenarios can show the behaviour over whole sequences. These include partial arrival spread over many cycles, a second codeword that is ignored while done is high, an illegal pair that blocks completion, and the reset values at the ports.

// File: rtl/dr_rx_pkg.sv
package dr_rx_pkg;

    typedef enum logic [1:0] {
        PK_SPACER  = 2'b00,
        PK_ZERO    = 2'b01,
        PK_ONE     = 2'b10,
        PK_ILLEGAL = 2'b11
    } pair_kind_e;

    typedef enum logic {
        PH_EMPTY = 1'b0,
        PH_FULL  = 1'b1
    } phase_e;

    function automatic pair_kind_e classify(input logic [1:0] pair);
        pair_kind_e k;
        unique case (pair)
            2'b00:   k = PK_SPACER;
            2'b01:   k = PK_ZERO;
            2'b10:   k = PK_ONE;
            default: k = PK_ILLEGAL;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/dr_pair_decode.sv
module dr_pair_decode
    import dr_rx_pkg::*;
(
    input  logic [1:0] pair_i,
    output logic       valid_o,
    output logic       spacer_o,
    output logic       illegal_o,
    output logic       bit_o
);

    pair_kind_e kind;

    always_comb begin
        kind      = classify(pair_i);
        valid_o   = 1'b0;
        spacer_o  = 1'b0;
        illegal_o = 1'b0;
        bit_o     = 1'b0;
        unique case (kind)
            PK_SPACER:  spacer_o  = 1'b1;
            PK_ZERO:    valid_o   = 1'b1;
            PK_ONE: begin
                valid_o = 1'b1;
                bit_o   = 1'b1;
            end
            PK_ILLEGAL: illegal_o = 1'b1;
            default:    illegal_o = 1'b1;
        endcase
    end

    // R8
    illegal_excl_chk: assert final (!(illegal_o && (valid_o || spacer_o)));

endmodule

// File: rtl/dr_reduce_tree.sv
module dr_reduce_tree #(
    parameter int N      = 8,
    parameter bit USE_OR = 1'b0
) (
    input  logic [N-1:0] leaf_i,
    output logic         root_o
);

    localparam int LVL = (N > 1) ? $clog2(N) : 0;
    localparam int P   = 1 << LVL;

    logic [2*P-1:1] node;

    generate
        for (genvar i = 0; i < P; i++) begin : g_leaf
            if (i < N) begin : g_real
                assign node[P+i] = leaf_i[i];
            end else begin : g_pad
                assign node[P+i] = USE_OR ? 1'b0 : 1'b1;
            end
        end
        for (genvar k = 1; k < P; k++) begin : g_node
            if (USE_OR) begin : g_or
                assign node[k] = node[2*k] | node[2*k+1];
            end else begin : g_and
                assign node[k] = node[2*k] & node[2*k+1];
            end
        end
    endgenerate

    assign root_o = node[1];

endmodule

// File: rtl/dr_phase_fsm.sv
module dr_phase_fsm
    import dr_rx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic all_valid_i,
    input  logic all_spacer_i,
    output logic done_o,
    output logic capture_o
);

    phase_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PH_EMPTY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_EMPTY: if (all_valid_i)  state_d = PH_FULL;
            PH_FULL:  if (all_spacer_i) state_d = PH_EMPTY;
            default:  state_d = PH_EMPTY;
        endcase
    end

    always_comb begin
        done_o    = (state_q == PH_FULL);
        capture_o = (state_q == PH_EMPTY) && all_valid_i;
    end

    // R2
    rise_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && all_valid_i) |=> done_o);
    // R3
    fall_on_spacer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && all_spacer_i) |=> !done_o);
    // R4
    hold_on_mix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!all_valid_i && !all_spacer_i) |=> $stable(done_o));

endmodule

// File: rtl/dr_completion_rx.sv
module dr_completion_rx
    import dr_rx_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*WIDTH-1:0] rails_i,
    output logic [WIDTH-1:0]   data_o,
    output logic               done_o,
    output logic               err_o
);

    logic [WIDTH-1:0] bit_valid, bit_spacer, bit_illegal, bit_val;
    logic all_valid, all_spacer, any_illegal, capture;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_bit
            dr_pair_decode u_dec (
                .pair_i    (rails_i[2*i+1:2*i]),
                .valid_o   (bit_valid[i]),
                .spacer_o  (bit_spacer[i]),
                .illegal_o (bit_illegal[i]),
                .bit_o     (bit_val[i])
            );
        end
    endgenerate

    dr_reduce_tree #(.N(WIDTH), .USE_OR(1'b0)) u_valid_tree (
        .leaf_i (bit_valid), .root_o (all_valid));
    dr_reduce_tree #(.N(WIDTH), .USE_OR(1'b0)) u_spacer_tree (
        .leaf_i (bit_spacer), .root_o (all_spacer));
    dr_reduce_tree #(.N(WIDTH), .USE_OR(1'b1)) u_illegal_tree (
        .leaf_i (bit_illegal), .root_o (any_illegal));

    dr_phase_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .all_valid_i  (all_valid),
        .all_spacer_i (all_spacer),
        .done_o       (done_o),
        .capture_o    (capture)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o <= '0;
            err_o  <= 1'b0;
        end else begin
            if (capture) data_o <= bit_val;
            err_o <= any_illegal;
        end
    end

    // R5
    capture_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        capture |=> (data_o == $past(bit_val)));
    // R6
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !capture |=> $stable(data_o));
    // R7
    err_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        any_illegal |=> err_o);
    // R7
    err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_illegal |=> !err_o);

endmodule

// File: tb/dr_completion_rx_bench.sv
module dr_completion_rx_bench;

    localparam int W        = 8;
    localparam int CLK_HALF = 5;

    logic           clk;
    logic           rst_n;
    logic [2*W-1:0] rails;
    logic [W-1:0]   data_o;
    logic           done_o, err_o;

    int n_chk, n_bad;
    logic         m_done, m_err;
    logic [W-1:0] m_data;

    dr_completion_rx #(.WIDTH(W)) u_dr_completion_rx (
        .clk(clk), .rst_n(rst_n), .rails_i(rails),
        .data_o(data_o), .done_o(done_o), .err_o(err_o));

    initial clk = 1'b0;
    always #(CLK_HALF) clk = ~clk;

    function automatic logic [2*W-1:0] enc(input logic [W-1:0] w);
        logic [2*W-1:0] r;
        for (int i = 0; i < W; i++) r[2*i +: 2] = w[i] ? 2'b10 : 2'b01;
        return r;
    endfunction

    function automatic logic f_all_valid(input logic [2*W-1:0] r);
        for (int i = 0; i < W; i++)
            if (r[2*i +: 2] != 2'b01 && r[2*i +: 2] != 2'b10) return 1'b0;
        return 1'b1;
    endfunction

    function automatic logic f_any_ill(input logic [2*W-1:0] r);
        for (int i = 0; i < W; i++) if (r[2*i +: 2] == 2'b11) return 1'b1;
        return 1'b0;
    endfunction

    function automatic logic [W-1:0] f_bits(input logic [2*W-1:0] r);
        logic [W-1:0] b;
        for (int i = 0; i < W; i++) b[i] = r[2*i+1];
        return b;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // check outputs for previous sample, then apply new sample
    task automatic step(input logic [2*W-1:0] r, input string tdone,
                        input string tdata, input string terr);
        @(negedge clk);
        chk(tdone, {31'd0, done_o}, {31'd0, m_done});
        chk(tdata, {24'd0, data_o}, {24'd0, m_data});
        chk(terr,  {31'd0, err_o},  {31'd0, m_err});
        rails = r;
        if (!m_done && f_all_valid(r)) begin
            m_done = 1'b1;
            m_data = f_bits(r);
        end else if (m_done && r == '0) begin
            m_done = 1'b0;
        end
        m_err = f_any_ill(r);
    endtask

    initial begin
        #(CLK_HALF * 2 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [2*W-1:0] r, cw;
        n_chk = 0; n_bad = 0;
        m_done = 0; m_err = 0; m_data = '0;
        void'($urandom(32'd20240611));
        rails = 16'hFFFF;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 done in reset", {31'd0, done_o}, 32'd0);
        chk("R1 err in reset", {31'd0, err_o}, 32'd0);
        chk("R1 data in reset", {24'd0, data_o}, 32'd0);
        rails = '0;
        rst_n = 1'b1;
        step('0, "R1 done", "R1 data", "R1 err");

        // full codeword arrives
        step(enc(8'hA5), "R1 done", "R1 data", "R7 err");
        step(enc(8'hA5), "R2 done rise", "R5 data", "R7 err");
        // new codeword with no spacer: ignored
        step(enc(8'h3C), "R2 done", "R5 data", "R7 err");
        step(enc(8'h3C), "R4 done", "R6 data", "R7 err");
        // partial return to spacer: hold
        step(enc(8'h3C) & 16'h00FF, "R4 done", "R6 data", "R7 err");
        step('0, "R4 done hold", "R6 data", "R7 err");
        step('0, "R3 done fall", "R6 data", "R7 err");
        // partial arrival over several cycles
        cw = enc(8'h96);
        step(cw & 16'h000F, "R3 done", "R6 data", "R7 err");
        step(cw & 16'h0FFF, "R4 done low", "R6 data", "R7 err");
        step(cw, "R4 done low", "R6 data", "R7 err");
        step(cw, "R2 done rise", "R5 data", "R7 err");
        // illegal pair blocks draining, raises err
        step(16'h0003, "R2 done", "R5 data", "R7 err");
        step(16'h0003, "R8 done hold", "R6 data", "R7 err high");
        step('0, "R8 done hold", "R6 data", "R7 err high");
        step('0, "R3 done fall", "R6 data", "R7 err clear");
        // illegal pair blocks completion
        step(enc(8'hFF) | 16'h0003, "R3 done", "R6 data", "R7 err");
        step(enc(8'h0F), "R8 done stays low", "R6 data", "R7 err high");
        step('0, "R2 done rise", "R5 data", "R7 err clear");

        // constrained random phases
        for (int t = 0; t < 400; t++) begin
            logic [W-1:0] w;
            w = W'($urandom);
            cw = enc(w);
            for (int k = 0; k < 3; k++) begin
                r = cw & 16'($urandom);
                for (int i = 0; i < W; i++)
                    if (r[2*i +: 2] != 2'b00) r[2*i +: 2] = cw[2*i +: 2];
                if ($urandom % 10 == 0) r[2*($urandom % W) +: 2] = 2'b11;
                step(r, "R4 done rand", "R6 data rand", "R7 err rand");
            end
            step(cw, "R2 done rand", "R5 data rand", "R7 err rand");
            step(cw & 16'($urandom), "R4 done rand", "R6 data rand", "R7 err rand");
            step('0, "R3 done rand", "R6 data rand", "R8 err rand");
        end
        step('0, "R3 done end", "R6 data end", "R7 err end");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule